// File: doc/BRIEF.md
# Strap-Configured Dead-Time Generator

This block turns a single PWM command into a complementary pair of gate drive signals, a high-side and a low-side, and puts a programmable dead time between them. When the PWM command changes, the output that is switching off goes low on the next clock edge. The output that is switching on stays low until a dead-time counter has run out. Both outputs are never high in the same cycle.

The dead time and an edge-speed code for the external driver come from strap pins. While the active-low reset/power-down input is low, the block reads these pins. It holds the last value it read when reset is released, and that value stays in force until the next reset. Four of the strap pins double as status outputs. After reset the block enables their output drivers and sends error flags out through them. The other two strap bits come from ordinary input pins and are inverted inside the block. Because of that inversion, the strap codes do not map to settings in a monotonic order.

The pads themselves are outside the block. It exposes a status input bus, a status output bus and one output-enable signal.

Top module: `strap_deadtime_gen`

## Requirements
- R1: The configuration is loaded from `stat_in`, `inb_in` and `ind_in` on every clock edge while `rst_pd_n` is low. It holds the last loaded value while `rst_pd_n` is high, even if those pins change after release.
- R2: The dead-time setting is decoded as follows:
  - Code = {stat_in[1], stat_in[0], ~ind_in}.
  - Setting = code + 1, where setting 1 is the shortest and setting 8 the longest.
  - Dead time = 2 × setting clock cycles, so code 0 gives 2 cycles and code 7 gives 16 cycles.
- R3: `edge_code` is a register equal to {stat_in[3], stat_in[2], ~inb_in} as captured under R1. Value 0 is the slowest edge (setting 1) and value 7 the fastest (setting 8). It is valid from the first clock edge after release and stays stable while the block runs.
- R4: When the clock samples `rst_pd_n` low, `gate_hi`, `gate_lo` and `stat_oe` are all 0 after that edge.
- R5: `stat_oe` becomes 1 on the first clock edge that samples `rst_pd_n` high. While the block runs, `stat_out` presents `err_flags` delayed by one clock.
- R6: On the clock edge that first samples a changed `pwm_in`, both gate outputs go low. `gate_hi` and `gate_lo` are never both 1.
- R7: After a PWM change, the output that turns on stays low for exactly the dead time of R2, counted in clock edges after the edge that saw the change. It then goes high.
- R8: If `pwm_in` changes again before the dead time has run out, the count restarts from the new change and both outputs stay low in the meantime.
- R9: Once the dead time has run out, `gate_hi` equals the sampled PWM level and `gate_lo` its complement. On the first edge after release, no dead time is applied and the output selected by `pwm_in` turns on at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pd_n | input | 1 | Active-low reset/power-down; straps are sampled while low |
| pwm_in | input | 1 | PWM command |
| stat_in | input | 4 | Pad input side of the shared strap/status pins |
| inb_in | input | 1 | Edge-speed strap bit (inverted internally) |
| ind_in | input | 1 | Dead-time strap bit (inverted internally) |
| err_flags | input | 4 | Error flags to send out on the status pins |
| stat_out | output | 4 | Pad output side of the status pins |
| stat_oe | output | 1 | Output enable for the status pins |
| edge_code | output | 3 | Latched edge-speed code for the driver |
| gate_hi | output | 1 | High-side gate drive |
| gate_lo | output | 1 | Low-side gate drive |

## Verification
The hardest case to reach is a second PWM change that arrives while the dead-time counter is still running, especially with the longest setting. If the counter were reloaded incorrectly, that case could shorten the gap or let the pending output rise early.

The bench straps the longest setting and toggles the PWM. It reverses the PWM a few cycles into the count, checks that both outputs stay low, and then measures the full dead time again from the reversal.

It also models the pad turnaround: once enabled, the status pins carry the error flags back on `stat_in`. This makes the pins change after release, which exercises the hold behaviour of R1.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    localparam int NSTAT    = 4;
    localparam int CODE_W   = 3;
    localparam int NSET     = 1 << CODE_W;
    localparam int STEP_CYC = 2;

    typedef struct packed {
        logic [CODE_W-1:0] edge_code;
        logic [CODE_W-1:0] gap_code;
    } strap_cfg_t;

    function automatic strap_cfg_t decode_straps(input logic [NSTAT-1:0] pins,
                                                 input logic inb, input logic ind);
        strap_cfg_t c;
        c.edge_code = {pins[3], pins[2], ~inb};
        c.gap_code  = {pins[1], pins[0], ~ind};
        return c;
    endfunction

    function automatic int gap_cycles(input logic [CODE_W-1:0] code, input int step);
        return (int'(code) + 1) * step;
    endfunction

endpackage

// File: rtl/dtg_strap_latch.sv
module dtg_strap_latch
    import dtg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSTAT-1:0] stat_in,
    input  logic             inb_in,
    input  logic             ind_in,
    input  logic [NSTAT-1:0] err_flags,
    output strap_cfg_t       cfg_q,
    output logic [NSTAT-1:0] stat_out,
    output logic             stat_oe
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= decode_straps(stat_in, inb_in, ind_in);
            stat_oe  <= 1'b0;
            stat_out <= '0;
        end else begin
            stat_oe  <= 1'b1;
            stat_out <= err_flags;
        end
    end

    p_cfg_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(cfg_q));

    p_oe_off_r4: assert property (@(posedge clk)
        rst |=> !stat_oe);

    p_oe_on_r5: assert property (@(posedge clk) disable iff (rst)
        !rst |=> stat_oe);

endmodule

// File: rtl/dtg_gap_core.sv
module dtg_gap_core
    import dtg_pkg::*;
#(
    parameter int STEP  = STEP_CYC,
    parameter int CNT_W = $clog2(NSET * STEP + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwm_in,
    input  logic [CODE_W-1:0] gap_code,
    output logic              gate_hi,
    output logic              gate_lo
);

    logic             pwm_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pwm_chg;
    logic [CNT_W-1:0] gap_len;

    assign pwm_chg = (pwm_in != pwm_q);
    assign gap_len = CNT_W'(gap_cycles(gap_code, STEP));

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_q   <= pwm_in;
            cnt_q   <= '0;
            gate_hi <= 1'b0;
            gate_lo <= 1'b0;
        end else if (pwm_chg) begin
            pwm_q   <= pwm_in;
            cnt_q   <= gap_len;
            gate_hi <= 1'b0;
            gate_lo <= 1'b0;
        end else begin
            if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            if (cnt_q <= CNT_W'(1)) begin
                gate_hi <= pwm_q;
                gate_lo <= ~pwm_q;
            end
        end
    end

    p_no_overlap_r6: assert property (@(posedge clk) disable iff (rst)
        !(gate_hi && gate_lo));

    p_off_on_change_r6: assert property (@(posedge clk) disable iff (rst)
        pwm_chg |=> (!gate_hi && !gate_lo));

    p_gap_low_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt_q > CNT_W'(1)) |-> (!gate_hi && !gate_lo));

    p_gates_reset_r4: assert property (@(posedge clk)
        rst |=> (!gate_hi && !gate_lo));

endmodule

// File: rtl/strap_deadtime_gen.sv
module strap_deadtime_gen
    import dtg_pkg::*;
#(
    parameter int STEP = STEP_CYC
) (
    input  logic             clk,
    input  logic             rst_pd_n,
    input  logic             pwm_in,
    input  logic [NSTAT-1:0] stat_in,
    input  logic             inb_in,
    input  logic             ind_in,
    input  logic [NSTAT-1:0] err_flags,
    output logic [NSTAT-1:0] stat_out,
    output logic             stat_oe,
    output logic [CODE_W-1:0] edge_code,
    output logic             gate_hi,
    output logic             gate_lo
);

    logic       rst;
    strap_cfg_t cfg;

    assign rst       = ~rst_pd_n;
    assign edge_code = cfg.edge_code;

    dtg_strap_latch u_straps (
        .clk       (clk),
        .rst       (rst),
        .stat_in   (stat_in),
        .inb_in    (inb_in),
        .ind_in    (ind_in),
        .err_flags (err_flags),
        .cfg_q     (cfg),
        .stat_out  (stat_out),
        .stat_oe   (stat_oe)
    );

    dtg_gap_core #(.STEP(STEP)) u_core (
        .clk      (clk),
        .rst      (rst),
        .pwm_in   (pwm_in),
        .gap_code (cfg.gap_code),
        .gate_hi  (gate_hi),
        .gate_lo  (gate_lo)
    );

    p_code_stable_r3: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(edge_code));

endmodule

// File: tb/tb_strap_deadtime_gen.sv
module tb_strap_deadtime_gen;

    logic       clk = 1'b0;
    logic       rst_pd_n = 1'b0;
    logic       pwm = 1'b0;
    logic [3:0] strap_drv = 4'hF;
    logic       inb = 1'b1, ind = 1'b1;
    logic [3:0] err_flags = 4'h0;
    logic [3:0] stat_in, stat_out;
    logic       stat_oe, gate_hi, gate_lo;
    logic [2:0] edge_code;

    int tests = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    // pad model: driven pins read back their own output value
    assign stat_in = stat_oe ? stat_out : strap_drv;

    strap_deadtime_gen dut (
        .clk(clk), .rst_pd_n(rst_pd_n), .pwm_in(pwm), .stat_in(stat_in),
        .inb_in(inb), .ind_in(ind), .err_flags(err_flags), .stat_out(stat_out),
        .stat_oe(stat_oe), .edge_code(edge_code), .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    // {straps[3:0], inb, ind, edge_code[2:0], dead[4:0]}
    localparam logic [13:0] VEC [8] = '{
        {4'b0000, 1'b1, 1'b1, 3'd0, 5'd2},
        {4'b0000, 1'b0, 1'b0, 3'd1, 5'd4},
        {4'b0101, 1'b1, 1'b0, 3'd2, 5'd8},
        {4'b1010, 1'b0, 1'b1, 3'd5, 5'd10},
        {4'b1111, 1'b1, 1'b1, 3'd6, 5'd14},
        {4'b1111, 1'b0, 1'b0, 3'd7, 5'd16},
        {4'b0110, 1'b1, 1'b0, 3'd2, 5'd12},
        {4'b1001, 1'b0, 1'b1, 3'd5, 5'd6}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [3:0] s, input logic b, input logic d);
        @(negedge clk);
        rst_pd_n = 1'b0; strap_drv = s; inb = b; ind = d; pwm = 1'b0;
        repeat (3) @(negedge clk);
        check(!gate_hi && !gate_lo && !stat_oe, "R4 reset state", {gate_hi, gate_lo, stat_oe}, 0);
        rst_pd_n = 1'b1;
        @(negedge clk);
        check(stat_oe == 1'b1, "R5 oe after release", stat_oe, 1);
        // R9: no dead time right after release, low side on for pwm=0
        check(gate_lo && !gate_hi, "R9 first edge after release", {gate_hi, gate_lo}, 1);
        // R1: pins now carry other values; config must not follow
        strap_drv = ~s; inb = ~b; ind = ~d;
        repeat (3) @(negedge clk);
    endtask

    // count low cycles of the output turning on after a PWM change
    task automatic measure(input bit want_hi, input int exp_d, input string req);
        int got = -1;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (gate_hi && gate_lo) check(0, "R6 overlap", 1, 0);
            if (k == 1) check(!(want_hi ? gate_lo : gate_hi), "R6 turn-off", k, 1);
            if ((want_hi ? gate_hi : gate_lo) && got < 0) begin
                got = k - 1;
                break;
            end
        end
        check(got == exp_d, req, got, exp_d);
    endtask

    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            logic [13:0] v = VEC[i];
            do_reset(v[13:10], v[9], v[8]);
            check(edge_code == v[7:5], "R3 edge code", edge_code, v[7:5]);
            @(negedge clk); pwm = 1'b1;
            measure(1'b1, v[4:0], "R2 R7 dead time rising");
            check(gate_hi && !gate_lo, "R9 steady high", {gate_hi, gate_lo}, 2);
            repeat (20) @(negedge clk);
            pwm = 1'b0;
            measure(1'b0, v[4:0], "R1 R7 dead time falling, straps held");
            check(edge_code == v[7:5], "R1 R3 edge code held", edge_code, v[7:5]);
        end

        // R8: reversal during the longest dead time
        do_reset(4'b0011, 1'b1, 1'b0);
        @(negedge clk); pwm = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(!gate_hi && !gate_lo, "R8 pending low", {gate_hi, gate_lo}, 0);
        end
        pwm = 1'b0;
        measure(1'b0, 16, "R8 restart count");

        // R5: status drive follows err_flags one cycle later
        @(negedge clk); err_flags = 4'b1010;
        @(negedge clk);
        check(stat_out == 4'b1010, "R5 status out", stat_out, 4'b1010);
        err_flags = 4'b0101;
        @(negedge clk);
        check(stat_out == 4'b0101, "R5 status follows", stat_out, 4'b0101);

        // R4: reset mid-run forces gates low and releases pins
        pwm = 1'b1; repeat (20) @(negedge clk);
        rst_pd_n = 1'b0;
        @(negedge clk);
        check(!gate_hi && !gate_lo && !stat_oe, "R4 reset mid-run", {gate_hi, gate_lo, stat_oe}, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule